// File: doc/BRIEF.md
# Four-Window ROM/RAM Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and its memories. The 64 KB CPU space is cut into four windows of unequal size: 0x0000–0x3FFF, 0x4000–0x8FFF, 0x9000–0xBFFF and 0xC000–0xFFFF. An 8-bit bank register holds one 2-bit field per window. A non-zero field places the window in one of three 64 KB RAM pages. A zero field places it in a write-protected 64 KB ROM image.

When the top window is in ROM mode, it is split into three parts. The lower part reads ROM. A 2 KB hole answers nothing. The upper 2 KB holds a four-register peripheral that repeats every four bytes.

The bank register is loaded from the CPU data bus by a dedicated I/O strobe. The mapping decode is combinational on the current register value, so a new mapping applies from the bus cycle after the strobe.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the bank register is 0x00, so a read in any window (outside the top-window hole and peripheral) asserts rom_sel.
- R2: Bank register bits [1:0], [3:2], [5:4] and [7:6] control the windows starting at 0x0000, 0x4000, 0x9000 and 0xC000 respectively.
- R3: A field value v of 1, 2 or 3 asserts ram_sel on a read or write and gives phys_addr = {v−1, cpu_addr} (bits [17:16] hold the page). mem_we follows cpu_wr.
- R4: A field value of 0 asserts rom_sel on a read, with phys_addr = {2'b01, cpu_addr}, i.e. ROM offset 0x10000 plus the CPU address.
- R5: A write to a window whose field is 0 asserts no select and no mem_we.
- R6: With the top field at 0, an access in 0xF000–0xF7FF asserts no select, and a read returns 0xFF.
- R7: With the top field at 0, an access in 0xF800–0xFFFF asserts io_sel with io_reg = cpu_addr[1:0], and a read returns io_rdata.
- R8: A cfg_wr pulse loads cpu_wdata into the bank register at the clock edge. Accesses in the same cycle use the old mapping, and accesses in the next cycle use the new one.
- R9: At most one select is active. A read through rom_sel or ram_sel returns mem_rdata. With no read or write, no select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | I/O strobe that loads the bank register from cpu_wdata |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU memory read |
| cpu_wr | input | 1 | CPU memory write |
| cpu_wdata | input | 8 | CPU write data |
| mem_rdata | input | 8 | Read data from ROM or RAM |
| io_rdata | input | 8 | Read data from the peripheral |
| phys_addr | output | 18 | Physical address; [17:16] page or ROM image |
| rom_sel | output | 1 | ROM chip select (reads only) |
| ram_sel | output | 1 | RAM chip select |
| mem_we | output | 1 | RAM write enable |
| io_sel | output | 1 | Peripheral select |
| io_reg | output | 2 | Peripheral register index |
| cpu_rdata | output | 8 | Read data to CPU |

## Verification
The only stored state is the bank register, and every access decodes it combinationally. A wrong field, a swapped field position or a missed load therefore shows up on the first access to the affected window: the wrong select, a wrong page in phys_addr[17:16], or a write enable during a protected write. The load timing is checked by accessing the window in the cycle of the strobe and again in the cycle right after it.

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PW = 18,
  parameter logic [DW-1:0] OPEN_BUS = '1,
  parameter logic [PW-AW-1:0] ROM_IMG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] io_rdata,
  output logic [PW-1:0] phys_addr,
  output logic          rom_sel,
  output logic          ram_sel,
  output logic          mem_we,
  output logic          io_sel,
  output logic [1:0]    io_reg,
  output logic [DW-1:0] cpu_rdata
);
  localparam logic [AW-1:0] WIN1_BASE = AW'(16'h4000);
  localparam logic [AW-1:0] WIN2_BASE = AW'(16'h9000);
  localparam logic [AW-1:0] WIN3_BASE = AW'(16'hC000);
  localparam int            HW        = PW - AW;

  logic [DW-1:0] bank_q;
  logic [1:0]    win;
  logic [1:0]    field;
  logic          in_ram, top_rom, in_hole, in_io, in_rom, access;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bank_q <= '0;
    else if (cfg_wr) bank_q <= cpu_wdata;

  always_comb begin
    if (cpu_addr < WIN1_BASE)      win = 2'd0;
    else if (cpu_addr < WIN2_BASE) win = 2'd1;
    else if (cpu_addr < WIN3_BASE) win = 2'd2;
    else                           win = 2'd3;
  end

  assign field   = bank_q[2*win +: 2];
  assign in_ram  = field != 2'd0;
  assign top_rom = (win == 2'd3) && !in_ram;
  assign in_hole = top_rom && (cpu_addr[AW-1:AW-5] == 5'b11110);
  assign in_io   = top_rom && (cpu_addr[AW-1:AW-5] == 5'b11111);
  assign in_rom  = !in_ram && !in_hole && !in_io;
  assign access  = cpu_rd || cpu_wr;

  assign ram_sel   = access && in_ram;
  assign mem_we    = cpu_wr && in_ram;
  assign rom_sel   = cpu_rd && in_rom;
  assign io_sel    = access && in_io;
  assign io_reg    = cpu_addr[1:0];
  assign phys_addr = in_ram ? {HW'(field - 2'd1), cpu_addr} : {ROM_IMG, cpu_addr};
  assign cpu_rdata = (rom_sel || (ram_sel && cpu_rd)) ? mem_rdata :
                     (io_sel && cpu_rd)               ? io_rdata  : OPEN_BUS;
endmodule

// File: rtl/bank_window_mapper_chk.sv
module bank_window_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_wdata,
  input logic [17:0] phys_addr,
  input logic        rom_sel,
  input logic        ram_sel,
  input logic        mem_we,
  input logic        io_sel,
  input logic [7:0]  cpu_rdata
);
  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel, io_sel}));

  assert_we_only_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ram_sel && cpu_wr));

  assert_rom_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (cpu_rd && !cpu_wr));

  assert_rom_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (phys_addr[17:16] == 2'b01 && phys_addr[15:0] == cpu_addr));

  assert_io_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (cpu_addr[15:11] == 5'b11111));

  assert_hole_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr[15:11] == 5'b11110 && !ram_sel)
      |-> (!rom_sel && !io_sel && cpu_rdata == 8'hFF));

  assert_cfg_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cpu_wdata[1:0] != 2'd0)
      |=> (!(cpu_rd && cpu_addr[15:14] == 2'b00) ||
           (ram_sel && phys_addr[17:16] == $past(cpu_wdata[1:0]) - 2'd1)));
endmodule

bind bank_window_mapper bank_window_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cpu_addr(cpu_addr),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .phys_addr(phys_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
  .mem_we(mem_we), .io_sel(io_sel), .cpu_rdata(cpu_rdata)
);

// File: tb/test_bank_window_mapper.sv
`timescale 1ns/100ps
module test_bank_window_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0, mem_rdata = 8'h5A, io_rdata = 8'hC3;
  logic [17:0] phys_addr;
  logic        rom_sel, ram_sel, mem_we, io_sel;
  logic [1:0]  io_reg;
  logic [7:0]  cpu_rdata;

  int   vectors = 0, errors = 0;
  logic [7:0] shadow = 8'h00;

  always #2.5 clk = ~clk;

  bank_window_mapper i_bank_window_mapper (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .mem_rdata(mem_rdata), .io_rdata(io_rdata), .phys_addr(phys_addr),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .mem_we(mem_we), .io_sel(io_sel),
    .io_reg(io_reg), .cpu_rdata(cpu_rdata));

  function automatic logic [1:0] field_of(logic [7:0] b, logic [15:0] a);
    if (a < 16'h4000)      return b[1:0];
    else if (a < 16'h9000) return b[3:2];
    else if (a < 16'hC000) return b[5:4];
    else                   return b[7:6];
  endfunction

  // Expected bundle: {rom,ram,we,io,rdata[7:0],phys[17:0],ioreg[1:0]}
  function automatic logic [31:0] model(logic [7:0] b, logic [15:0] a, logic rd, logic wr,
                                        logic [7:0] md, logic [7:0] id);
    logic [1:0] f = field_of(b, a);
    logic top = (a >= 16'hC000) && f == 2'd0;
    logic hole = top && a[15:11] == 5'b11110;
    logic io = top && a[15:11] == 5'b11111;
    logic rom = rd && f == 2'd0 && !hole && !io;
    logic ram = (rd || wr) && f != 2'd0;
    logic ios = (rd || wr) && io;
    logic [7:0] rdv = (rd && (rom || ram)) ? md : (rd && ios) ? id : 8'hFF;
    logic [17:0] ph = (f != 2'd0) ? {f - 2'd1, a} : {2'b01, a};
    return {rom, ram, wr && f != 2'd0, ios, rdv, ph, a[1:0]};
  endfunction

  task automatic check(string tag);
    logic [31:0] exp = model(shadow, cpu_addr, cpu_rd, cpu_wr, mem_rdata, io_rdata);
    logic [31:0] act = {rom_sel, ram_sel, mem_we, io_sel, cpu_rdata, phys_addr, io_reg};
    if (!(exp[31] || exp[30])) begin exp[19:2] = '0; act[19:2] = '0; end
    if (!exp[28]) begin exp[1:0] = '0; act[1:0] = '0; end
    if (!cpu_rd) begin exp[27:20] = '0; act[27:20] = '0; end
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h bank=%h rd=%b wr=%b actual=%h expected=%h",
               tag, cpu_addr, shadow, cpu_rd, cpu_wr, act, exp);
    end
  endtask

  task automatic access(logic [15:0] a, logic rd, logic wr, string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cfg_wr = 1'b0;
    mem_rdata = 8'($urandom); io_rdata = 8'($urandom); cpu_wdata = 8'($urandom);
    #1 check(tag);
  endtask

  // R8: the strobe cycle still uses the old mapping; the next cycle uses the new one
  task automatic load_bank(logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cpu_wdata = v; cpu_addr = 16'h0123; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1 check("R8 old mapping during strobe");
    @(posedge clk); shadow = v;
    @(negedge clk); cfg_wr = 1'b0;
    #1 check("R8 new mapping next cycle");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access(16'h0000, 1, 0, "R1 reset window0 ROM");
    access(16'h5000, 1, 0, "R1 reset window1 ROM");
    access(16'hA000, 1, 0, "R1 reset window2 ROM");
    access(16'hC000, 1, 0, "R1 reset window3 ROM");
    access(16'h1234, 0, 1, "R5 write to ROM ignored");
    access(16'hEFFF, 0, 1, "R5 top ROM write ignored");
    access(16'hF000, 1, 0, "R6 hole low edge");
    access(16'hF7FF, 1, 0, "R6 hole high edge");
    access(16'hF400, 0, 1, "R6 hole write");
    access(16'hF800, 1, 0, "R7 peripheral base");
    access(16'hFFFE, 1, 0, "R7 peripheral mirror");
    access(16'hFA07, 0, 1, "R7 peripheral write");
    access(16'h2000, 0, 0, "R9 idle no select");
    load_bank(8'b00_00_00_01);
    access(16'h3FFF, 0, 1, "R2 field0 window0 RAM page0");
    access(16'h4000, 1, 0, "R2 window1 stays ROM");
    load_bank(8'b00_00_10_00);
    access(16'h8FFF, 1, 0, "R2 field1 window1 page1");
    access(16'h9000, 1, 0, "R2 window2 stays ROM");
    load_bank(8'b00_11_00_00);
    access(16'hBFFF, 0, 1, "R3 field2 window2 page2");
    load_bank(8'b10_00_00_00);
    access(16'hF000, 1, 0, "R3 top RAM covers hole");
    access(16'hFFFF, 0, 1, "R3 top RAM covers peripheral");
    load_bank(8'h00);
    access(16'hF801, 1, 0, "R7 peripheral after return to ROM");
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 9) == 0) load_bank(8'($urandom));
      else begin
        int k = $urandom_range(0, 2);
        access(16'($urandom), k == 0, k == 1, "R9 random access");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule